// File: doc/BRIEF.md
# Single-Cycle Bypass Arbiter for One Router Output

This block sits at one output of a five-port mesh router and decides which of the other four inputs may send a freshly arrived header flit across the crossbar without going through the normal two-phase virtual-channel and switch allocation. An input holds such a header in its low-priority bypass slot. The slot is claimed only when the header is bound for this output and both the output and the input were seen free in the previous cycle. Each cycle the block picks at most one claimed slot and issues a crossbar grant for it.

Order among the competing inputs is kept in a pairwise priority matrix. An input is masked when any input that beats it in the matrix is also requesting. The one unmasked requester wins, and after that grant it drops to the lowest priority. While any bypass slot is claimed, the block tells the normal first-phase VC arbiters to hold back their requests for this output. While an input is claimed or is streaming a granted packet, it cancels the switch requests of that input's normal channels. The streaming state ends when the tail flit leaves.

Top module: `wing_fast_arb`

## Requirements
- R1: After reset no grant is issued, the normal-arbitration block output is low, no input has its normal switch requests cancelled, and the priority order is input 0 highest, then 1, 2 and 3.
- R2: An input's bypass slot becomes claimed on the clock edge after a cycle with arr_vld_i high for that input, its direction field (DIR_W bits at position k*DIR_W) equal to OUT_IDX, out_free_i high, and in_free_i high for that input, provided the input is neither claimed nor streaming. In every other case no claim is made.
- R3: gnt_o is one-hot or zero. A bit is set only for an input whose slot is claimed and whose ovc_ok_i bit is high.
- R4: Among the claimed inputs with ovc_ok_i high, the grant goes to the one ranked highest in the current priority order.
- R5: The priority order changes only on a clock edge at the end of a cycle with a grant. At that edge the winner moves to the lowest rank and the others keep their relative order.
- R6: A claimed input that is not granted stays claimed and competes again in the next cycle.
- R7: demote_i clears an ungranted claim at the next edge, and no grant follows from it.
- R8: nvc_block_o is high exactly when at least one input slot is claimed.
- R9: A granted input enters the streaming state at the next edge and stays in it until the edge after a cycle with its tail_i high. sw_cancel_o for an input is high while that input is claimed or streaming.
- R10: No grant is issued in a cycle in which any input is streaming through this output.
- R11: A claimed input with ovc_ok_i low makes no request and gets no grant, but it keeps its claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arr_vld_i | input | N_IN | New header arriving at each candidate input |
| arr_dir_i | input | N_IN*DIR_W | Output direction of each arriving header |
| out_free_i | input | 1 | This output was not awarded by switch allocation last cycle |
| in_free_i | input | N_IN | Each input was not awarded by switch allocation last cycle |
| ovc_ok_i | input | N_IN | Output VC granted, or no VC mask pending, for each input |
| demote_i | input | N_IN | Turn a claimed slot back into a normal channel |
| tail_i | input | N_IN | Tail flit of the streaming packet leaves |
| gnt_o | output | N_IN | One-hot crossbar grant for this output |
| nvc_block_o | output | 1 | Suppress first-phase normal VC requests for this output |
| sw_cancel_o | output | N_IN | Cancel normal-channel switch requests per input |

## Verification
Two things can fall in the same cycle: a grant that rotates the priority order, and a fresh claim or demotion at another input. A second case is a pending claim that is blocked while a granted packet is still streaming. Directed sequences bring these about: two inputs claim together, a winner is granted while a third input arrives, and a tail flit leaves while another claim waits. Constrained random traffic then mixes arrivals, demotions and tails. Each cycle, a rank-list model in the bench predicts the grant, the blocking output and the per-input cancels, and these are compared with the block's outputs.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
    localparam int unsigned ROUTER_PORTS = 5;
    localparam int unsigned DIR_BITS     = 3;

    function automatic int unsigned cand_count(input int unsigned ports);
        return ports - 1;
    endfunction
endpackage

// File: rtl/wfa_slot_bank.sv
module wfa_slot_bank #(
    parameter int unsigned N_IN    = 4,
    parameter int unsigned DIR_W   = 3,
    parameter int unsigned OUT_IDX = 0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_IN-1:0]    arr_vld_i,
    input  logic [N_IN*DIR_W-1:0] arr_dir_i,
    input  logic               out_free_i,
    input  logic [N_IN-1:0]    in_free_i,
    input  logic [N_IN-1:0]    demote_i,
    input  logic [N_IN-1:0]    tail_i,
    input  logic [N_IN-1:0]    gnt_i,
    output logic [N_IN-1:0]    pend_o,
    output logic [N_IN-1:0]    hold_o
);
    typedef struct packed {
        logic [N_IN-1:0] pend;
        logic [N_IN-1:0] hold;
    } slot_t;

    slot_t st_q, st_d;
    logic [N_IN-1:0] claim;

    for (genvar k = 0; k < N_IN; k++) begin : g_claim
        logic dir_hit;
        assign dir_hit  = (arr_dir_i[k*DIR_W +: DIR_W] == DIR_W'(OUT_IDX));
        assign claim[k] = arr_vld_i[k] & dir_hit & out_free_i & in_free_i[k]
                        & ~st_q.pend[k] & ~st_q.hold[k];
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N_IN; k++) begin
            if (st_q.pend[k]) begin
                st_d.pend[k] = ~gnt_i[k] & ~demote_i[k];
            end else begin
                st_d.pend[k] = claim[k];
            end
            st_d.hold[k] = gnt_i[k] | (st_q.hold[k] & ~tail_i[k]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign hold_o = st_q.hold;

    for (genvar k = 0; k < N_IN; k++) begin : g_chk
        // R9: a granted slot streams on the next cycle
        a_r9_hold_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gnt_i[k] |=> hold_o[k]);
        // R2: a claim only appears after a matching arrival on a free path
        a_r2_claim_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!pend_o[k] ##1 pend_o[k]) |-> $past(arr_vld_i[k] && out_free_i && in_free_i[k]));
        // R6: an ungranted, undemoted claim persists
        a_r6_claim_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_o[k] && !gnt_i[k] && !demote_i[k]) |=> pend_o[k]);
    end
endmodule

// File: rtl/wfa_prio_matrix.sv
module wfa_prio_matrix #(
    parameter int unsigned N_IN = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_IN-1:0] req_i,
    input  logic [N_IN-1:0] gnt_i,
    output logic [N_IN-1:0] unmasked_o
);
    typedef logic [N_IN-1:0][N_IN-1:0] mat_t;

    mat_t beats_q, beats_d;
    logic [N_IN-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < N_IN; i++) begin
            for (int j = 0; j < N_IN; j++) begin
                if (j != i && req_i[j] && beats_q[j][i]) begin
                    mask[i] = 1'b1;
                end
            end
        end
    end

    assign unmasked_o = req_i & ~mask;

    always_comb begin
        beats_d = beats_q;
        for (int w = 0; w < N_IN; w++) begin
            if (gnt_i[w]) begin
                for (int j = 0; j < N_IN; j++) begin
                    if (j != w) begin
                        beats_d[w][j] = 1'b0;
                        beats_d[j][w] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < N_IN; i++) begin
                for (int j = 0; j < N_IN; j++) begin
                    beats_q[i][j] <= (i < j);
                end
            end
        end else begin
            beats_q <= beats_d;
        end
    end

    // R5: order only moves on a cycle with a grant
    a_r5_order_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_i == '0) |=> $stable(beats_q));

    for (genvar i = 0; i < N_IN; i++) begin : g_anti
        for (genvar j = i + 1; j < N_IN; j++) begin : g_pair
            // R4: every pair has exactly one winner in the matrix
            a_r4_total_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
                beats_q[i][j] != beats_q[j][i]);
        end
    end
endmodule

// File: rtl/wfa_pick.sv
module wfa_pick #(
    parameter int unsigned N_IN = 4
) (
    input  logic [N_IN-1:0] cand_i,
    input  logic            busy_i,
    output logic [N_IN-1:0] gnt_o
);
    always_comb begin
        gnt_o = '0;
        if (!busy_i) begin
            for (int k = N_IN - 1; k >= 0; k--) begin
                if (cand_i[k]) begin
                    gnt_o = '0;
                    gnt_o[k] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wing_fast_arb.sv
module wing_fast_arb #(
    parameter int unsigned NUM_PORTS = wfa_pkg::ROUTER_PORTS,
    parameter int unsigned DIR_W     = wfa_pkg::DIR_BITS,
    parameter int unsigned OUT_IDX   = 0,
    localparam int unsigned N_IN     = wfa_pkg::cand_count(NUM_PORTS)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_IN-1:0]       arr_vld_i,
    input  logic [N_IN*DIR_W-1:0] arr_dir_i,
    input  logic                  out_free_i,
    input  logic [N_IN-1:0]       in_free_i,
    input  logic [N_IN-1:0]       ovc_ok_i,
    input  logic [N_IN-1:0]       demote_i,
    input  logic [N_IN-1:0]       tail_i,
    output logic [N_IN-1:0]       gnt_o,
    output logic                  nvc_block_o,
    output logic [N_IN-1:0]       sw_cancel_o
);
    logic [N_IN-1:0] pend, hold, req, cand, gnt;
    logic            busy;

    wfa_slot_bank #(.N_IN(N_IN), .DIR_W(DIR_W), .OUT_IDX(OUT_IDX)) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arr_vld_i  (arr_vld_i),
        .arr_dir_i  (arr_dir_i),
        .out_free_i (out_free_i),
        .in_free_i  (in_free_i),
        .demote_i   (demote_i),
        .tail_i     (tail_i),
        .gnt_i      (gnt),
        .pend_o     (pend),
        .hold_o     (hold)
    );

    assign req  = pend & ovc_ok_i;
    assign busy = |hold;

    wfa_prio_matrix #(.N_IN(N_IN)) i_matrix (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req),
        .gnt_i      (gnt),
        .unmasked_o (cand)
    );

    wfa_pick #(.N_IN(N_IN)) i_pick (
        .cand_i (cand),
        .busy_i (busy),
        .gnt_o  (gnt)
    );

    assign gnt_o       = gnt;
    assign nvc_block_o = |pend;
    assign sw_cancel_o = pend | hold;

    // R3: at most one grant per cycle
    a_r3_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    // R3 and R11: grant only to a claimed input with its output VC ready
    a_r3_gnt_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != '0) |-> ((gnt_o & pend & ovc_ok_i) == gnt_o));
    // R10: nothing granted while a packet streams
    a_r10_no_gnt_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold != '0) |-> (gnt_o == '0));
endmodule

// File: tb/test_wing_fast_arb.sv
module test_wing_fast_arb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NP   = 5;
    localparam int unsigned DW   = 3;
    localparam int unsigned OI   = 2;
    localparam int unsigned N    = NP - 1;
    localparam int unsigned WDOG = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    arr_vld = '0;
    logic [N*DW-1:0] arr_dir = '0;
    logic            out_free = 1'b0;
    logic [N-1:0]    in_free = '0, ovc_ok = '0, demote = '0, tail = '0;
    logic [N-1:0]    gnt, cancel;
    logic            block;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    bit [N-1:0] m_pend, m_hold;
    int         m_rank[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    wing_fast_arb #(.NUM_PORTS(NP), .DIR_W(DW), .OUT_IDX(OI)) i_wing_fast_arb (
        .clk_i(clk), .rst_ni(rst_n), .arr_vld_i(arr_vld), .arr_dir_i(arr_dir),
        .out_free_i(out_free), .in_free_i(in_free), .ovc_ok_i(ovc_ok),
        .demote_i(demote), .tail_i(tail), .gnt_o(gnt), .nvc_block_o(block),
        .sw_cancel_o(cancel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [N-1:0] exp_gnt();
        bit [N-1:0] g = '0;
        if (m_hold == '0) begin
            for (int r = 0; r < N; r++) begin
                if (m_pend[m_rank[r]] && ovc_ok[m_rank[r]]) begin
                    g[m_rank[r]] = 1'b1;
                    break;
                end
            end
        end
        return g;
    endfunction

    task automatic model_reset();
        m_pend = '0;
        m_hold = '0;
        for (int r = 0; r < N; r++) m_rank[r] = r;
    endtask

    // inputs already driven; compare mid-cycle, then advance model at the edge
    task automatic step(input string tag);
        bit [N-1:0] g;
        bit [N-1:0] np, nh;
        int w;
        #1;
        g = exp_gnt();
        check({tag, " grant"}, 32'(gnt), 32'(g));
        check({"R8 ", tag, " block"}, 32'(block), 32'(|m_pend));
        check({"R9 ", tag, " cancel"}, 32'(cancel), 32'(m_pend | m_hold));
        w = -1;
        for (int k = 0; k < N; k++) begin
            if (m_pend[k]) np[k] = !g[k] && !demote[k];
            else np[k] = arr_vld[k] && (arr_dir[k*DW +: DW] == DW'(OI)) && out_free
                         && in_free[k] && !m_hold[k];
            nh[k] = g[k] || (m_hold[k] && !tail[k]);
            if (g[k]) w = k;
        end
        @(posedge clk);
        m_pend = np;
        m_hold = nh;
        if (w >= 0) begin
            int p = 0;
            for (int r = 0; r < N; r++) if (m_rank[r] == w) p = r;
            for (int r = p; r < N - 1; r++) m_rank[r] = m_rank[r+1];
            m_rank[N-1] = w;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        arr_vld = '0; demote = '0; tail = '0; out_free = 1'b1; in_free = '1;
    endtask

    task automatic arrive(input int k, input int dir);
        arr_vld[k] = 1'b1;
        arr_dir[k*DW +: DW] = DW'(dir);
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd7341;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 grant", 32'(gnt), 0);
        check("R1 block", 32'(block), 0);
        check("R1 cancel", 32'(cancel), 0);
        rst_n = 1'b1;
        idle_in();
        ovc_ok = '1;

        // R2: wrong direction, busy output, busy input give no claim
        arrive(0, 1); step("R2");
        idle_in(); out_free = 1'b0; arrive(1, OI); step("R2");
        idle_in(); in_free[2] = 1'b0; arrive(2, OI); step("R2");
        idle_in(); step("R2");
        check("R2 no claim", 32'(block), 0);

        // R11: claim with output VC not ready
        ovc_ok = '0; arrive(1, OI); step("R11");
        idle_in(); step("R11");
        step("R11");
        check("R11 kept", 32'(block), 1);

        // R4: two claims, reset order picks lower index; R10 while streaming
        demote[1] = 1'b1; step("R7");
        idle_in(); ovc_ok = '1;
        check("R7 cleared", 32'(block), 0);
        arrive(0, OI); arrive(3, OI); step("R4");
        idle_in(); step("R4");
        arrive(1, OI); step("R10");
        idle_in(); step("R10");
        step("R6");
        tail[0] = 1'b1; step("R9");
        idle_in(); step("R4");
        tail = '1; step("R9");
        idle_in(); step("R9");
        tail = '1; step("R9");
        idle_in();
        // R5: previous winners now rank low; 0 and 2 together
        arrive(0, OI); arrive(2, OI); step("R5");
        idle_in(); step("R5");
        tail = '1; step("R5");
        idle_in(); step("R5");
        tail = '1; step("R5");
        idle_in(); step("R5");

        // mixed random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int k = 0; k < N; k++) begin
                arr_vld[k] = ($urandom % 4) == 0;
                arr_dir[k*DW +: DW] = DW'(($urandom % 3 == 0) ? (($urandom % NP)) : OI);
                in_free[k] = ($urandom % 5) != 0;
                ovc_ok[k]  = ($urandom % 4) != 0;
                demote[k]  = ($urandom % 12) == 0;
                tail[k]    = ($urandom % 3) == 0;
            end
            out_free = ($urandom % 4) != 0;
            step("R4 rand");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule